// File: doc/BRIEF.md
# Machine-Mode CSR and Instruction-Fence Unit

This block serves the system-instruction path of a small 32-bit integer/multiply core that runs only in machine mode and has no instruction cache. It carries out the six CSR read-modify-write instructions against a minimal register set and recognises the instruction-stream fence as a legal operation. The set has four entries: a constant ISA-description word, a fully writable scratch word, a trap-vector base that only ever operates in direct mode, and an interrupt-pending word that mirrors the timer and external interrupt lines.

The execute stage presents one instruction per cycle. It supplies the operation code, the 12-bit CSR address, the 5-bit source field (a register index or an unsigned immediate), the source register value and the destination index. In the same cycle the unit returns the CSR's old value, an illegal-instruction flag and a fence acknowledge. Architectural state changes at the next clock edge, and only while the commit strobe is high. The instruction fence has nothing to flush because the core has no caches or prefetch queues, so it completes with no side effects.

Top module: `csr_fence_unit`

## Requirements
- R1: `op_i` codes are 001 swap, 010 set-bits, 011 clear-bits, 101/110/111 the immediate forms of those three, 000 the instruction fence and 100 reserved. `rdata_o` shows the addressed CSR's value before the update in the same cycle for any legal CSR instruction whose `rd_i` is nonzero, and reads 0 otherwise.
- R2: The scratch register at address 0x340 holds all 32 bits and resets to 0.
- R3: The written value is the operand for swap, old OR operand for set, and old AND NOT operand for clear.
- R4: The immediate forms use `rs1_i` zero-extended to 32 bits as the operand, and `src_i` is ignored.
- R5: Set and clear do not write when `rs1_i` is 0, in both the register and the immediate form. Swap always writes.
- R6: Address 0x301 always reads 0x40001100. Any write to it raises `illegal_o`. A set or clear with `rs1_i` = 0 to it is legal.
- R7: An access to an address that is not implemented raises `illegal_o`. A write to an address whose bits 11:10 are 11 also raises it.
- R8: The trap vector at 0x305 stores bits 31:2 and resets to 0. Bits 1:0 always read 0, so a write that asks for vectored mode cannot enable it.
- R9: Address 0x344 reads the timer line at bit 7 and the external line at bit 11, with every other bit 0. Writes to it are legal and change nothing.
- R10: The fence (op 000) raises `fence_ack_o` and does not raise `illegal_o`. It leaves all CSRs unchanged.
- R11: Op code 100 raises `illegal_o`.
- R12: No CSR changes when `commit_i` is low or when the instruction is illegal. An illegal instruction returns `rdata_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A system instruction is present this cycle |
| op_i | input | 3 | Operation code (see R1) |
| csr_addr_i | input | 12 | CSR address |
| rs1_i | input | 5 | Source register index or unsigned immediate |
| rd_i | input | 5 | Destination register index |
| src_i | input | 32 | Source register value |
| commit_i | input | 1 | Allow the state update at the next edge |
| irq_timer_i | input | 1 | Machine timer interrupt line |
| irq_ext_i | input | 1 | Machine external interrupt line |
| rdata_o | output | 32 | Old CSR value for the destination register |
| illegal_o | output | 1 | Illegal-instruction flag |
| fence_ack_o | output | 1 | Instruction fence accepted |

## Verification
Two things can happen in the same cycle: the combinational read of a CSR's old value and the committed write of its new value. A committed swap, set or clear must report the pre-write value in its own cycle, and the next instruction must see the post-write value. The bench therefore issues chains of back-to-back committed operations on the scratch and trap-vector registers, each of which reads what the previous one wrote. Each returned value is compared with a reference model that the bench updates only at the commit edge. A second overlap is the interrupt-pending read while a line toggles. The lines are changed between instructions, and the read is judged against the line levels held in that cycle.

// File: rtl/csr_pkg.sv
package csr_pkg;

  typedef enum logic [2:0] {
    OP_FENCE = 3'b000,
    OP_SWAP  = 3'b001,
    OP_SET   = 3'b010,
    OP_CLR   = 3'b011,
    OP_RSV   = 3'b100,
    OP_SWAPI = 3'b101,
    OP_SETI  = 3'b110,
    OP_CLRI  = 3'b111
  } csr_op_e;

  localparam logic [11:0] A_ISA     = 12'h301;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_PEND    = 12'h344;

  localparam int PEND_TIMER_BIT = 7;
  localparam int PEND_EXT_BIT   = 11;

  typedef struct packed {
    logic isa;
    logic tvec;
    logic scratch;
    logic pend;
  } csr_sel_t;

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [11:0]     addr_i,
  input  logic [4:0]      rs1_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] old_i,
  output csr_sel_t        sel_o,
  output logic            is_csr_o,
  output logic            illegal_o,
  output logic            wr_en_o,
  output logic [XLEN-1:0] wdata_o,
  output logic            fence_o
);
  localparam int IMM_W = 5;

  csr_op_e         op;
  logic [1:0]      kind;
  logic [XLEN-1:0] operand;
  logic            known;
  logic            wants_write;
  logic            read_only;
  logic            reserved;

  always_comb begin
    op          = csr_op_e'(op_i);
    kind        = op_i[1:0];
    operand     = op_i[2] ? {{(XLEN-IMM_W){1'b0}}, rs1_i} : src_i;
    is_csr_o    = valid_i && (kind != 2'b00);
    fence_o     = valid_i && (op == OP_FENCE);
    reserved    = valid_i && (op == OP_RSV);

    sel_o.isa     = (addr_i == A_ISA);
    sel_o.tvec    = (addr_i == A_TVEC);
    sel_o.scratch = (addr_i == A_SCRATCH);
    sel_o.pend    = (addr_i == A_PEND);
    known         = |sel_o;

    wants_write = (kind == 2'b01) || (rs1_i != '0);
    read_only   = (addr_i[11:10] == 2'b11) || sel_o.isa;

    illegal_o = reserved || (is_csr_o && (!known || (wants_write && read_only)));
    wr_en_o   = is_csr_o && wants_write && !illegal_o;

    case (kind)
      2'b01:   wdata_o = operand;
      2'b10:   wdata_o = old_i | operand;
      2'b11:   wdata_o = old_i & ~operand;
      default: wdata_o = old_i;
    endcase
  end
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] ISA_WORD  = 32'h4000_1100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_i,
  input  logic            wr_en_i,
  input  csr_sel_t        sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            irq_timer_i,
  input  logic            irq_ext_i,
  output logic [XLEN-1:0] rdata_o
);
  localparam int TVEC_LSB = 2;

  logic [XLEN-1:0]        scratch_q, scratch_d;
  logic [XLEN-1:TVEC_LSB] tvec_q, tvec_d;
  logic                   scratch_en, tvec_en;
  logic [XLEN-1:0]        pend_val;

  always_comb begin
    scratch_en = commit_i && wr_en_i && sel_i.scratch;
    tvec_en    = commit_i && wr_en_i && sel_i.tvec;
    scratch_d  = wdata_i;
    tvec_d     = wdata_i[XLEN-1:TVEC_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          scratch_q <= '0;
    else if (scratch_en) scratch_q <= scratch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tvec_q <= '0;
    else if (tvec_en) tvec_q <= tvec_d;
  end

  always_comb begin
    pend_val                 = '0;
    pend_val[PEND_TIMER_BIT] = irq_timer_i;
    pend_val[PEND_EXT_BIT]   = irq_ext_i;
    rdata_o = '0;
    if (sel_i.isa)     rdata_o = ISA_WORD;
    if (sel_i.tvec)    rdata_o = {tvec_q, {TVEC_LSB{1'b0}}};
    if (sel_i.scratch) rdata_o = scratch_q;
    if (sel_i.pend)    rdata_o = pend_val;
  end

  // R2: a committed scratch write lands whole
  a_r2_scratch_load: assert property (@(posedge clk) disable iff (!rst_n)
    scratch_en |=> scratch_q == $past(wdata_i));

  // R8: the trap vector keeps only the base, never the mode bits
  a_r8_tvec_direct: assert property (@(posedge clk) disable iff (!rst_n)
    tvec_en |=> {tvec_q, 2'b00} == ($past(wdata_i) & ~32'h3));

  // R12: no commit, no change
  a_r12_hold_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(scratch_q) && $stable(tvec_q));

  // R9: pending word follows the lines
  a_r9_pend_follow: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i.pend |-> (rdata_o[PEND_TIMER_BIT] == irq_timer_i) &&
                   (rdata_o[PEND_EXT_BIT] == irq_ext_i) &&
                   ($countones(rdata_o) == 32'(irq_timer_i) + 32'(irq_ext_i)));
endmodule

// File: rtl/csr_fence_unit.sv
module csr_fence_unit
  import csr_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] ISA_WORD = 32'h4000_1100,
  parameter int              RST_SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [4:0]      rs1_i,
  input  logic [4:0]      rd_i,
  input  logic [XLEN-1:0] src_i,
  input  logic            commit_i,
  input  logic            irq_timer_i,
  input  logic            irq_ext_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            illegal_o,
  output logic            fence_ack_o
);
  logic            rst_sync_n;
  csr_sel_t        sel;
  logic            is_csr, illegal, wr_en, fence;
  logic [XLEN-1:0] old_val, wdata;

  csr_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  csr_decode #(.XLEN(XLEN)) u_dec (
    .valid_i   (valid_i),
    .op_i      (op_i),
    .addr_i    (csr_addr_i),
    .rs1_i     (rs1_i),
    .src_i     (src_i),
    .old_i     (old_val),
    .sel_o     (sel),
    .is_csr_o  (is_csr),
    .illegal_o (illegal),
    .wr_en_o   (wr_en),
    .wdata_o   (wdata),
    .fence_o   (fence)
  );

  csr_regs #(.XLEN(XLEN), .ISA_WORD(ISA_WORD)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .commit_i    (commit_i),
    .wr_en_i     (wr_en),
    .sel_i       (sel),
    .wdata_i     (wdata),
    .irq_timer_i (irq_timer_i),
    .irq_ext_i   (irq_ext_i),
    .rdata_o     (old_val)
  );

  always_comb begin
    rdata_o     = (is_csr && !illegal && (rd_i != '0)) ? old_val : '0;
    illegal_o   = illegal;
    fence_ack_o = fence;
  end

  // R6: the ISA word is constant whenever it is returned
  a_r6_isa_const: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && csr_addr_i == A_ISA && !illegal_o && rd_i != '0) |-> rdata_o == ISA_WORD);

  // R10: the fence is legal and touches nothing
  a_r10_fence_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fence_ack_o |-> !illegal_o && !wr_en && rdata_o == '0);

  // R11: reserved op code traps
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && op_i == 3'b100) |-> illegal_o);

  // R12: an illegal instruction reports zero and writes nothing
  a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal_o |-> !wr_en && rdata_o == '0 && !fence_ack_o);

  // R5: set/clear with a zero source field never write
  a_r5_no_write_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && op_i[1] && rs1_i == '0) |-> !wr_en);
endmodule

// File: tb/csr_fence_unit_bench.sv
module csr_fence_unit_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] ISA = 32'h4000_1100;

  logic        clk, rst_n, valid_i, commit_i, irq_timer_i, irq_ext_i;
  logic [2:0]  op_i;
  logic [11:0] csr_addr_i;
  logic [4:0]  rs1_i, rd_i;
  logic [31:0] src_i, rdata_o;
  logic        illegal_o, fence_ack_o;

  csr_fence_unit u_csr_fence_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .csr_addr_i(csr_addr_i), .rs1_i(rs1_i), .rd_i(rd_i), .src_i(src_i),
    .commit_i(commit_i), .irq_timer_i(irq_timer_i), .irq_ext_i(irq_ext_i),
    .rdata_o(rdata_o), .illegal_o(illegal_o), .fence_ack_o(fence_ack_o)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] m_scratch, m_tvec;
  logic [31:0] q_rd[$];
  logic        q_ill[$];
  logic        q_ack[$];
  string       q_req[$];
  event        ev_chk;

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h301: return ISA;
      12'h305: return m_tvec;
      12'h340: return m_scratch;
      12'h344: return (32'(irq_ext_i) << 11) | (32'(irq_timer_i) << 7);
      default: return 32'h0;
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [11:0] a, input logic [4:0] rs1,
                        input logic [4:0] rd, input logic [31:0] src, input logic cm,
                        input string req);
    logic [1:0]  kind;
    logic [31:0] opnd, old, nv;
    logic        csr, known, ww, ro, ill;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; csr_addr_i = a; rs1_i = rs1; rd_i = rd;
    src_i = src; commit_i = cm;
    kind  = op[1:0];
    opnd  = op[2] ? {27'b0, rs1} : src;
    csr   = (kind != 2'b00);
    known = (a == 12'h301) || (a == 12'h305) || (a == 12'h340) || (a == 12'h344);
    ww    = (kind == 2'b01) || (rs1 != 5'd0);
    ro    = (a[11:10] == 2'b11) || (a == 12'h301);
    ill   = (op == 3'b100) || (csr && (!known || (ww && ro)));
    old   = model_read(a);
    nv    = (kind == 2'b01) ? opnd : (kind == 2'b10) ? (old | opnd) : (old & ~opnd);
    q_rd.push_back((csr && !ill && rd != 5'd0) ? old : 32'h0);
    q_ill.push_back(ill);
    q_ack.push_back(op == 3'b000);
    q_req.push_back(req);
    -> ev_chk;
    @(posedge clk);
    if (cm && csr && !ill && ww) begin
      if (a == 12'h340) m_scratch = nv;
      if (a == 12'h305) m_tvec = nv & ~32'h3;
    end
    #1 valid_i = 1'b0; commit_i = 1'b0;
  endtask

  // monitor: pops one expectation per driven instruction, samples mid-cycle
  initial begin
    forever begin
      @(ev_chk);
      #(CLK_P/4);
      begin
        string r;
        r = q_req.pop_front();
        check({r, " rdata"},   rdata_o,            q_rd.pop_front());
        check({r, " illegal"}, {31'b0, illegal_o}, {31'b0, q_ill.pop_front()});
        check({r, " ack"},     {31'b0, fence_ack_o}, {31'b0, q_ack.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; commit_i = 1'b0; op_i = 3'b0; csr_addr_i = '0;
    rs1_i = '0; rd_i = '0; src_i = '0; irq_timer_i = 1'b0; irq_ext_i = 1'b0;
    m_scratch = '0; m_tvec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R12 idle outputs after reset
    check("R12 idle rdata", rdata_o, 32'h0);
    check("R12 idle illegal", {31'b0, illegal_o}, 32'h0);
    // R2 R8 reset values, R6 ISA constant
    run_op(3'b010, 12'h340, 5'd0, 5'd1, 32'hFFFF_FFFF, 1'b1, "R2 reset scratch R5");
    run_op(3'b010, 12'h305, 5'd0, 5'd1, 32'h0, 1'b1, "R8 reset tvec");
    run_op(3'b010, 12'h301, 5'd0, 5'd1, 32'h0, 1'b1, "R6 isa read");
    // R1 R2 R3 back-to-back committed chain
    run_op(3'b001, 12'h340, 5'd4, 5'd2, 32'hA5A5_5A5A, 1'b1, "R3 swap");
    run_op(3'b010, 12'h340, 5'd4, 5'd2, 32'h0F00_00F0, 1'b1, "R3 set");
    run_op(3'b011, 12'h340, 5'd4, 5'd2, 32'h0000_FFFF, 1'b1, "R3 clear");
    run_op(3'b001, 12'h340, 5'd0, 5'd2, 32'hFFFF_FFFF, 1'b1, "R5 swap x0 writes R2");
    run_op(3'b010, 12'h340, 5'd0, 5'd2, 32'h0, 1'b1, "R2 full width");
    // R4 immediate forms
    run_op(3'b111, 12'h340, 5'h1F, 5'd3, 32'h0, 1'b1, "R4 clri");
    run_op(3'b110, 12'h340, 5'h15, 5'd3, 32'hFFFF_FFFF, 1'b1, "R4 seti");
    run_op(3'b101, 12'h340, 5'h1F, 5'd3, 32'hDEAD_BEEF, 1'b1, "R4 swapi");
    run_op(3'b010, 12'h340, 5'd0, 5'd3, 32'h0, 1'b1, "R4 readback");
    // R5 zero source does not write
    run_op(3'b011, 12'h340, 5'd0, 5'd3, 32'hFFFF_FFFF, 1'b1, "R5 clear x0");
    run_op(3'b110, 12'h340, 5'd0, 5'd3, 32'h0, 1'b1, "R5 seti zero");
    run_op(3'b010, 12'h340, 5'd0, 5'd3, 32'h0, 1'b1, "R5 readback");
    // R12 no commit
    run_op(3'b001, 12'h340, 5'd1, 5'd3, 32'h1234_5678, 1'b0, "R12 uncommitted");
    run_op(3'b010, 12'h340, 5'd0, 5'd3, 32'h0, 1'b1, "R12 readback");
    // R1 rd x0 hides old value but still writes
    run_op(3'b001, 12'h340, 5'd1, 5'd0, 32'h0BAD_F00D, 1'b1, "R1 rd x0");
    run_op(3'b010, 12'h340, 5'd0, 5'd3, 32'h0, 1'b1, "R1 readback");
    // R6 R7 R12 illegal accesses
    run_op(3'b001, 12'h301, 5'd2, 5'd3, 32'h0, 1'b1, "R6 isa write");
    run_op(3'b110, 12'h301, 5'd1, 5'd3, 32'h0, 1'b1, "R6 isa seti");
    run_op(3'b011, 12'h301, 5'd0, 5'd3, 32'h0, 1'b1, "R6 isa clear x0");
    run_op(3'b001, 12'h7C0, 5'd2, 5'd3, 32'h1, 1'b1, "R7 unimplemented");
    run_op(3'b010, 12'hC00, 5'd0, 5'd3, 32'h0, 1'b1, "R7 ro region read");
    run_op(3'b001, 12'hC40, 5'd2, 5'd3, 32'h1, 1'b1, "R7 ro region write");
    // R8 direct mode only
    run_op(3'b001, 12'h305, 5'd2, 5'd3, 32'h8000_0101, 1'b1, "R8 tvec write vectored");
    run_op(3'b101, 12'h305, 5'd3, 5'd3, 32'h0, 1'b1, "R8 tvec readback swapi");
    run_op(3'b010, 12'h305, 5'd0, 5'd3, 32'h0, 1'b1, "R8 tvec immediate");
    // R9 pending word
    irq_timer_i = 1'b1;
    run_op(3'b010, 12'h344, 5'd0, 5'd3, 32'h0, 1'b1, "R9 timer");
    irq_ext_i = 1'b1;
    run_op(3'b010, 12'h344, 5'd0, 5'd3, 32'h0, 1'b1, "R9 both");
    irq_timer_i = 1'b0;
    run_op(3'b001, 12'h344, 5'd4, 5'd3, 32'hFFFF_FFFF, 1'b1, "R9 write ignored");
    irq_ext_i = 1'b0;
    run_op(3'b010, 12'h344, 5'd0, 5'd3, 32'h0, 1'b1, "R9 none");
    // R10 fence, R11 reserved
    run_op(3'b000, 12'h340, 5'd7, 5'd3, 32'hFFFF_FFFF, 1'b1, "R10 fence");
    run_op(3'b100, 12'h340, 5'd7, 5'd3, 32'hFFFF_FFFF, 1'b1, "R11 reserved");
    run_op(3'b010, 12'h340, 5'd0, 5'd3, 32'h0, 1'b1, "R10 R11 readback");
    @(negedge clk);
    check("R1 scoreboard drained", 32'(q_req.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule